// File: doc/BRIEF.md
# Exception Mode Stack and Cause Registers

This block holds the exception state of a small processor core in two 16-bit registers. The status register carries an 8-bit interrupt mask and a three-entry stack of mode/enable pairs. The cause register carries one pending flag for each of five hardware interrupt lines and a 4-bit exception code. The control unit drives two take inputs. One is a synchronous trap, raised by the instruction that faults. The other is an interrupt, accepted between instructions. Either take pushes the mode stack and puts the core in kernel mode with interrupts off. A return pulse pops the stack.

The block gives the control unit one interrupt request line. It is the enabled, unmasked OR of the pending flags. Software reads both registers on the output buses and writes them through one shared write-data bus, which has a separate write enable for each register.

Top module: `exc_state_regs`

## Requirements
- R1: After a cycle with rst_n low, status_q and cause_q are 0 and irq_req is low.
- R2: When status_we is high and there is no take or return pulse, status_q takes wdata[15:8] and wdata[5:0] in the next cycle. Status bits 7:6 always read 0.
- R3: A take (trap_take or intr_take high) updates the status register in the next cycle. Status bits 5:2 take the old bits 3:0, bits 1:0 become 0, and the mask in bits 15:8 is kept. Pairs are (k at the odd bit, e at the even bit), with current in 1:0, previous in 3:2 and old in 5:4. k=0 means kernel mode and e=1 means enabled.
- R4: A rfe pulse with no take loads status bits 3:0 from the old bits 5:2 and leaves bits 5:4 unchanged.
- R5: Cause bits 14:10 equal hw_irq (bit 10 is line 0) as registered on the previous edge. They follow the lines as they fall, and software writes have no effect on them. Cause bits 15, 9:6 and 1:0 read 0.
- R6: The exception code sits in cause bits 5:2. A trap loads trap_code, an interrupt take loads 0, and a cause write with no take loads wdata[5:2].
- R7: A trap and an interrupt in the same cycle record the trap code. In the same cycle, a take beats a return pulse and both software writes, and a return pulse beats a status write.
- R8: irq_req is high exactly when status bit 0 is 1 and at least one pending bit is set where the matching hardware mask bit in status bits 12:8 is also 1. Mask bits 15:13 have no effect on irq_req.
- R9: Every 4-bit code value is recorded unchanged, including 4, 5, 6, 7, 8, 9, 10 and 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hw_irq | input | 5 | Hardware interrupt request lines |
| trap_take | input | 1 | Synchronous trap accepted this cycle |
| trap_code | input | 4 | Code of the trap |
| intr_take | input | 1 | Interrupt accepted this cycle |
| rfe | input | 1 | Return-from-exception pulse |
| status_we | input | 1 | Software write of status |
| cause_we | input | 1 | Software write of cause |
| wdata | input | 16 | Software write data |
| status_q | output | 16 | Status register |
| cause_q | output | 16 | Cause register |
| irq_req | output | 1 | Interrupt request to control unit |

## Verification
Two pairs of functions can fall in the same cycle. A trap can coincide with an interrupt take, and a take can coincide with a software write. The bench raises trap_take and intr_take together and expects the trap code. It then pulses a take, or a return, in the same cycle as all-ones writes to both registers. The result counts as correct when the stack has moved and the written values are nowhere to be seen.

// File: rtl/exc_state_regs.sv
module exc_state_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  hw_irq,
  input  logic        trap_take,
  input  logic [3:0]  trap_code,
  input  logic        intr_take,
  input  logic        rfe,
  input  logic        status_we,
  input  logic        cause_we,
  input  logic [15:0] wdata,
  output logic [15:0] status_q,
  output logic [15:0] cause_q,
  output logic        irq_req
);

  logic [7:0] mask_q;
  logic [5:0] mode_q;
  logic [4:0] pend_q;
  logic [3:0] code_q;
  logic       take;

  assign take = trap_take | intr_take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      mode_q <= '0;
      pend_q <= '0;
      code_q <= '0;
    end else begin
      pend_q <= hw_irq;
      if (take) begin
        mode_q <= {mode_q[3:0], 2'b00};
        code_q <= trap_take ? trap_code : 4'd0;
      end else begin
        if (rfe) begin
          mode_q <= {mode_q[5:4], mode_q[5:2]};
        end else if (status_we) begin
          mode_q <= wdata[5:0];
          mask_q <= wdata[15:8];
        end
        if (cause_we) code_q <= wdata[5:2];
      end
    end
  end

  assign status_q = {mask_q, 2'b00, mode_q};
  assign cause_q  = {1'b0, pend_q, 4'b0000, code_q, 2'b00};
  assign irq_req  = mode_q[0] & (|(pend_q & mask_q[4:0]));

  a_r3_push: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take || intr_take) |=> (status_q[1:0] == 2'b00) &&
      (status_q[5:2] == $past(status_q[3:0])) && $stable(status_q[15:8]));

  a_r4_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe && !trap_take && !intr_take) |=>
      (status_q[5:4] == $past(status_q[5:4])) && (status_q[3:0] == $past(status_q[5:2])));

  a_r5_pend_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cause_q[14:10] == $past(hw_irq));

  a_r7_trap_wins: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |=> cause_q[5:2] == $past(trap_code));

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !status_q[0] |-> !irq_req);

endmodule

// File: tb/exc_state_regs_tb.sv
module exc_state_regs_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic [4:0] hw_irq = 0;
  logic trap_take = 0, intr_take = 0, rfe = 0, status_we = 0, cause_we = 0;
  logic [3:0] trap_code = 0;
  logic [15:0] wdata = 0;
  logic [15:0] status_q, cause_q;
  logic irq_req;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  exc_state_regs dut_i (.clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .trap_take(trap_take),
    .trap_code(trap_code), .intr_take(intr_take), .rfe(rfe), .status_we(status_we),
    .cause_we(cause_we), .wdata(wdata), .status_q(status_q), .cause_q(cause_q),
    .irq_req(irq_req));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    trap_take = 0; intr_take = 0; rfe = 0; status_we = 0; cause_we = 0;
  endtask

  task automatic wr_status(logic [15:0] d);
    status_we = 1; wdata = d; cyc();
  endtask

  task automatic t_reset();
    chk("R1 status", status_q, 16'h0000);
    chk("R1 cause", cause_q, 16'h0000);
    chk("R1 irq", {15'd0, irq_req}, 16'd0);
  endtask

  task automatic t_write();
    wr_status(16'hFFFF);
    chk("R2 status write", status_q, 16'hFF3F);
    cause_we = 1; wdata = 16'hFFFF; cyc();
    chk("R5 R6 cause write", cause_q, 16'h003C);
  endtask

  task automatic t_pending();
    hw_irq = 5'b10101; cyc();
    chk("R5 pending capture", {11'd0, cause_q[14:10]}, 16'h0015);
    cause_we = 1; wdata = 16'h0000; cyc();
    chk("R5 pending ignores write", {11'd0, cause_q[14:10]}, 16'h0015);
    hw_irq = 5'b00100; cyc();
    chk("R5 pending follows fall", {11'd0, cause_q[14:10]}, 16'h0004);
    hw_irq = 0; cyc();
  endtask

  task automatic t_irq();
    wr_status(16'h0101);
    hw_irq = 5'b00001; cyc();
    chk("R8 irq enabled and unmasked", {15'd0, irq_req}, 16'd1);
    hw_irq = 5'b00010; cyc();
    chk("R8 irq masked level", {15'd0, irq_req}, 16'd0);
    hw_irq = 5'b00001; wr_status(16'h0100);
    chk("R8 irq e=0", {15'd0, irq_req}, 16'd0);
    wr_status(16'hE001);
    chk("R8 software mask no effect", {15'd0, irq_req}, 16'd0);
    hw_irq = 0; cyc();
  endtask

  task automatic t_take_rfe();
    wr_status(16'hA52D);
    trap_take = 1; trap_code = 4'd9; cyc();
    chk("R3 push", status_q, 16'hA534);
    chk("R6 trap code", cause_q, 16'h0024);
    rfe = 1; cyc();
    chk("R4 pop", status_q, 16'hA53D);
    wr_status(16'h000F);
    intr_take = 1; cyc();
    chk("R3 push twice a", status_q, 16'h003C);
    chk("R6 interrupt code 0", cause_q, 16'h0000);
    intr_take = 1; cyc();
    chk("R3 push twice b", status_q, 16'h0030);
    rfe = 1; cyc();
    chk("R4 pop keeps old", status_q, 16'h003C);
  endtask

  task automatic t_collide();
    trap_take = 1; intr_take = 1; trap_code = 4'd12; cyc();
    chk("R7 trap beats interrupt", cause_q, 16'h0030);
    wr_status(16'h0003);
    trap_take = 1; trap_code = 4'd8; status_we = 1; cause_we = 1; wdata = 16'hFFFF; cyc();
    chk("R7 take beats status write", status_q, 16'h000C);
    chk("R7 take beats cause write", cause_q, 16'h0020);
    rfe = 1; status_we = 1; wdata = 16'hFF3F; cyc();
    chk("R7 rfe beats status write", status_q, 16'h0003);
  endtask

  task automatic t_codes();
    logic [3:0] codes [9] = '{4'd0, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd12};
    for (int i = 0; i < 9; i++) begin
      trap_take = 1; trap_code = codes[i]; cyc();
      chk("R9 code value", cause_q, {10'd0, codes[i], 2'b00});
    end
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(); cyc();
    t_reset();
    rst_n = 1; cyc();
    t_reset();
    t_write();
    t_pending();
    t_irq();
    t_take_rfe();
    t_collide();
    t_codes();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule